// File: doc/BRIEF.md
# Load/Store Data Aligner

This block connects a processor core to a data memory built from 32-bit words with a write enable for each byte. For each request it decodes a 6-bit memory opcode that selects one of five load kinds or three store kinds. It forms the byte address from a base register and a signed 16-bit displacement. It then issues a word address, byte-lane enables and store data that has been steered into the right lanes.

For loads, the word the memory returns one cycle later is cut down to the addressed byte, halfword or word. That value is then sign- or zero-extended. A halfword or word request whose address is not a multiple of its size is not sent to memory, and a misalignment pulse is raised in its place.

Timing is fixed. The memory-side outputs are registered and appear one cycle after the request is accepted. The memory is assumed to register its read word at the next clock edge. The extended load result is valid in the cycle after that.

Top module: `lsa_aligner`

## Requirements
- R1: The byte address is base_i plus offset_i sign-extended to 32 bits, with wrap-around modulo 2^32. mem_addr_o carries bits [31:2] of that address in the cycle after the request.
- R2: Opcode 101000 stores a byte. The enables are a single bit at position addr[1:0], and mem_wdata_o holds store_data_i[7:0] copied into all four lanes. mem_we_o is 1.
- R3: Opcode 101001 stores a halfword. The enables are 4'b0011 when addr[1:0] is 0 and 4'b1100 when it is 2, and mem_wdata_o holds store_data_i[15:0] copied into both halves.
- R4: Opcode 101011 stores a word. The enables are 4'b1111 and mem_wdata_o equals store_data_i.
- R5: Opcode 100000 (sign-extending) and opcode 100100 (zero-extending) load a byte. Lane n occupies bits [8n+7:8n] of the read word, and n = addr[1:0]. The result appears on load_data_o with load_valid_o two cycles after the request.
- R6: Opcode 100001 (sign-extending) and opcode 100101 (zero-extending) load a halfword. The halfword is taken from bits [31:16] when addr[1] is 1 and from bits [15:0] otherwise.
- R7: Opcode 100011 loads the whole read word unchanged. For every load, mem_we_o is 0 and the enables mark the lanes being read.
- R8: A halfword access with addr[0] set, or a word access with addr[1:0] nonzero, gives misaligned_o = 1 in the next cycle. In that case mem_req_o = 0, the enables are all zero and no load result follows.
- R9: When req_valid_i is low, or the opcode is not one of the eight above, nothing is issued. mem_req_o, misaligned_o and every enable stay 0 and no load result follows. load_data_o is 0 whenever load_valid_o is 0.
- R10: While rst_ni is low, mem_req_o, mem_we_o, mem_be_o, misaligned_o and load_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is presented this cycle |
| opcode_i | input | 6 | Memory opcode |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| store_data_i | input | 32 | Register value to be stored |
| mem_rdata_i | input | 32 | Read word from memory, one cycle after mem_req_o |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Write when 1, read when 0 |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Store data copied into lanes |
| misaligned_o | output | 1 | Misaligned request was dropped |
| load_valid_o | output | 1 | load_data_o holds a load result |
| load_data_o | output | 32 | Extracted and extended load value |

## Verification
Directed stores of each size land at every legal lane and are then read back as whole words. This separates wrong lane steering from wrong copying of the store data. Loads of every flavour are run over words whose byte and halfword sign bits alternate, so that swapped lanes show up as well as confused sign and zero extension. Displacements that are negative or carry past bit 31 test the address adder. Halfword and word requests at every odd or unaligned lane test the misalignment gate, and unknown opcodes and idle cycles test that nothing leaks out. A long mixed sequence of back-to-back loads and stores through a bench memory then checks the two-cycle load timing against stores that have just completed.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  localparam logic [5:0] OPC_LD_BYTE_S = 6'b100000;
  localparam logic [5:0] OPC_LD_BYTE_U = 6'b100100;
  localparam logic [5:0] OPC_LD_HALF_S = 6'b100001;
  localparam logic [5:0] OPC_LD_HALF_U = 6'b100101;
  localparam logic [5:0] OPC_LD_WORD   = 6'b100011;
  localparam logic [5:0] OPC_ST_BYTE   = 6'b101000;
  localparam logic [5:0] OPC_ST_HALF   = 6'b101001;
  localparam logic [5:0] OPC_ST_WORD   = 6'b101011;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      known;
    logic      store;
    logic      sext;
    acc_size_e size;
  } op_info_t;

endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
  import lsa_pkg::*;
(
  input  logic [5:0] opcode_i,
  output op_info_t   info_o
);

  always_comb begin
    info_o = '{known: 1'b1, store: 1'b0, sext: 1'b0, size: SZ_BYTE};
    unique case (opcode_i)
      OPC_LD_BYTE_S: info_o.sext = 1'b1;
      OPC_LD_BYTE_U: ;
      OPC_LD_HALF_S: begin info_o.size = SZ_HALF; info_o.sext = 1'b1; end
      OPC_LD_HALF_U: info_o.size = SZ_HALF;
      OPC_LD_WORD:   info_o.size = SZ_WORD;
      OPC_ST_BYTE:   info_o.store = 1'b1;
      OPC_ST_HALF:   begin info_o.store = 1'b1; info_o.size = SZ_HALF; end
      OPC_ST_WORD:   begin info_o.store = 1'b1; info_o.size = SZ_WORD; end
      default:       info_o.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [OFFS_W-1:0]        offset_i,
  input  acc_size_e                size_i,
  output logic [ADDR_W-LANE_W-1:0] word_addr_o,
  output logic [LANE_W-1:0]        lane_o,
  output logic                     misaligned_o
);

  localparam int EXT_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] ea;

  assign ea          = base_i + {{EXT_W{offset_i[OFFS_W-1]}}, offset_i};
  assign word_addr_o = ea[ADDR_W-1:LANE_W];
  assign lane_o      = ea[LANE_W-1:0];

  always_comb begin
    unique case (size_i)
      SZ_HALF: misaligned_o = lane_o[0];
      SZ_WORD: misaligned_o = |lane_o;
      default: misaligned_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              enable_i,
  input  acc_size_e         size_i,
  input  logic [$clog2(DATA_W/8)-1:0] lane_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic [DATA_W/8-1:0] be_o,
  output logic [DATA_W-1:0] wdata_o
);

  localparam int NUM_LANES = DATA_W / 8;

  logic [NUM_LANES-1:0] size_mask;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: size_mask = NUM_LANES'(1);
      SZ_HALF: size_mask = NUM_LANES'(3);
      default: size_mask = '1;
    endcase
  end

  assign be_o = enable_i ? (size_mask << lane_i) : '0;

  // copy the narrow value into every lane; enables alone choose what lands
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[8*g +: 8] = store_data_i[7:0];
        SZ_HALF: wdata_o[8*g +: 8] = store_data_i[8*(g%2) +: 8];
        default: wdata_o[8*g +: 8] = store_data_i[8*g +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              valid_i,
  input  acc_size_e         size_i,
  input  logic              sext_i,
  input  logic [$clog2(DATA_W/8)-1:0] lane_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int LANE_W = $clog2(DATA_W / 8);

  logic [7:0]        byte_val;
  logic [15:0]       half_val;
  logic [LANE_W-2:0] half_sel;

  assign half_sel = lane_i[LANE_W-1:1];
  assign byte_val = rdata_i[{lane_i, 3'b000} +: 8];
  assign half_val = rdata_i[{half_sel, 4'b0000} +: 16];

  always_comb begin
    if (!valid_i) begin
      data_o = '0;
    end else begin
      unique case (size_i)
        SZ_BYTE: data_o = {{(DATA_W-8){sext_i & byte_val[7]}}, byte_val};
        SZ_HALF: data_o = {{(DATA_W-16){sext_i & half_val[15]}}, half_val};
        default: data_o = rdata_i;
      endcase
    end
  end

endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic [5:0]                  opcode_i,
  input  logic [ADDR_W-1:0]           base_i,
  input  logic [OFFS_W-1:0]           offset_i,
  input  logic [DATA_W-1:0]           store_data_i,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr_o,
  output logic [DATA_W/8-1:0]         mem_be_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  output logic                        misaligned_o,
  output logic                        load_valid_o,
  output logic [DATA_W-1:0]           load_data_o
);

  localparam int NUM_LANES = DATA_W / 8;
  localparam int LANE_W    = $clog2(NUM_LANES);
  localparam int WADDR_W   = ADDR_W - LANE_W;

  op_info_t             info;
  logic [WADDR_W-1:0]   word_addr;
  logic [LANE_W-1:0]    lane;
  logic                 misaligned;
  logic                 accept, issue;
  logic [NUM_LANES-1:0] be_d;
  logic [DATA_W-1:0]    wdata_d;

  // load metadata, stage 1 (request out) and stage 2 (data back)
  logic              ld1_q, ld2_q;
  logic [LANE_W-1:0] lane1_q, lane2_q;
  acc_size_e         size1_q, size2_q;
  logic              sext1_q, sext2_q;

  lsa_decode u_decode (
    .opcode_i (opcode_i),
    .info_o   (info)
  );

  lsa_addr_gen #(
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W),
    .LANE_W (LANE_W)
  ) u_addr_gen (
    .base_i       (base_i),
    .offset_i     (offset_i),
    .size_i       (info.size),
    .word_addr_o  (word_addr),
    .lane_o       (lane),
    .misaligned_o (misaligned)
  );

  assign accept = req_valid_i & info.known;
  assign issue  = accept & ~misaligned;

  lsa_store_steer #(
    .DATA_W (DATA_W)
  ) u_store_steer (
    .enable_i     (issue),
    .size_i       (info.size),
    .lane_i       (lane),
    .store_data_i (store_data_i),
    .be_o         (be_d),
    .wdata_o      (wdata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o    <= 1'b0;
      mem_we_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_be_o     <= '0;
      mem_wdata_o  <= '0;
      misaligned_o <= 1'b0;
      ld1_q        <= 1'b0;
      lane1_q      <= '0;
      size1_q      <= SZ_BYTE;
      sext1_q      <= 1'b0;
    end else begin
      mem_req_o    <= issue;
      mem_we_o     <= issue & info.store;
      mem_be_o     <= be_d;
      misaligned_o <= accept & misaligned;
      ld1_q        <= issue & ~info.store;
      if (issue) begin
        mem_addr_o <= word_addr;
        lane1_q    <= lane;
        size1_q    <= info.size;
        sext1_q    <= info.sext;
      end
      if (issue && info.store) begin
        mem_wdata_o <= wdata_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld2_q   <= 1'b0;
      lane2_q <= '0;
      size2_q <= SZ_BYTE;
      sext2_q <= 1'b0;
    end else begin
      ld2_q <= ld1_q;
      if (ld1_q) begin
        lane2_q <= lane1_q;
        size2_q <= size1_q;
        sext2_q <= sext1_q;
      end
    end
  end

  lsa_load_extract #(
    .DATA_W (DATA_W)
  ) u_load_extract (
    .valid_i (ld2_q),
    .size_i  (size2_q),
    .sext_i  (sext2_q),
    .lane_i  (lane2_q),
    .rdata_i (mem_rdata_i),
    .data_o  (load_data_o)
  );

  assign load_valid_o = ld2_q;

endmodule

// File: rtl/lsa_aligner_checker.sv
module lsa_aligner_checker #(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 mem_req_o,
  input logic                 mem_we_o,
  input logic [NUM_LANES-1:0] mem_be_o,
  input logic                 misaligned_o,
  input logic                 load_valid_o,
  input logic [DATA_W-1:0]    load_data_o
);

  a_r8_misaligned_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_o |-> (!mem_req_o && mem_be_o == '0));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |-> (mem_be_o == '0 && !mem_we_o));

  a_r9_req_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $past(req_valid_i));

  a_r9_load_data_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_valid_o |-> load_data_o == '0);

  a_r5_load_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_o |-> $past(mem_req_o && !mem_we_o));

  a_r4_be_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
                   || $countones(mem_be_o) == NUM_LANES));

endmodule

bind lsa_aligner lsa_aligner_checker #(
  .NUM_LANES (NUM_LANES),
  .DATA_W    (DATA_W)
) u_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_be_o     (mem_be_o),
  .misaligned_o (misaligned_o),
  .load_valid_o (load_valid_o),
  .load_data_o  (load_data_o)
);

// File: tb/lsa_aligner_tb.sv
module lsa_aligner_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] base = '0;
  logic [15:0] offset = '0;
  logic [31:0] sdata = '0;
  logic [31:0] rdata_q = '0;
  logic        mem_req_o, mem_we_o, misaligned_o, load_valid_o;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o, load_data_o;

  int checks = 0;
  int fails  = 0;
  bit run_checks = 0;
  bit finished = 0;

  logic [31:0] mem [MEM_WORDS];

  lsa_aligner u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .opcode_i     (opcode),
    .base_i       (base),
    .offset_i     (offset),
    .store_data_i (sdata),
    .mem_rdata_i  (rdata_q),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_be_o     (mem_be_o),
    .mem_wdata_o  (mem_wdata_o),
    .misaligned_o (misaligned_o),
    .load_valid_o (load_valid_o),
    .load_data_o  (load_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural model state
  bit          e_req, e_we, e_mis, e_lv;
  logic [29:0] e_addr;
  logic [3:0]  e_be;
  logic [31:0] e_wdata, e_ld;
  string       e_tag = "R9", e_ltag = "R9";
  bit          p_ld, p_sext;
  int          p_idx, p_lane, p_n;
  string       p_tag = "R9";

  function automatic logic [31:0] extract(input logic [31:0] w, input int lane, input int n, input bit sx);
    logic [31:0] s;
    s = w >> (8 * lane);
    if (n == 1) return sx ? {{24{s[7]}}, s[7:0]} : {24'h0, s[7:0]};
    if (n == 2) return sx ? {{16{s[15]}}, s[15:0]} : {16'h0, s[15:0]};
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_req = 0; e_we = 0; e_mis = 0; e_lv = 0; e_addr = '0; e_be = '0;
      e_wdata = '0; e_ld = '0; p_ld = 0; e_tag = "R9"; e_ltag = "R9";
      rdata_q <= '0;
    end else begin
      int          n;
      bit          sx, st, known, aligned;
      string       tag;
      logic [31:0] ea;
      int          lane;
      // bench memory, driven by the DUT outputs
      if (mem_req_o && !mem_we_o) rdata_q <= mem[mem_addr_o[3:0]];
      if (mem_req_o && mem_we_o)
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[mem_addr_o[3:0]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
      // model: load return
      e_lv   = p_ld;
      e_ltag = p_tag;
      e_ld   = p_ld ? extract(mem[p_idx], p_lane, p_n, p_sext) : 32'h0;
      // model: new request
      known = 1; st = 0; sx = 0; n = 1; tag = "R5";
      case (opcode)
        6'b100000: begin n = 1; sx = 1; tag = "R5"; end
        6'b100100: begin n = 1; tag = "R5"; end
        6'b100001: begin n = 2; sx = 1; tag = "R6"; end
        6'b100101: begin n = 2; tag = "R6"; end
        6'b100011: begin n = 4; tag = "R7"; end
        6'b101000: begin n = 1; st = 1; tag = "R2"; end
        6'b101001: begin n = 2; st = 1; tag = "R3"; end
        6'b101011: begin n = 4; st = 1; tag = "R4"; end
        default:   known = 0;
      endcase
      ea      = base + {{16{offset[15]}}, offset};
      lane    = int'(ea[1:0]);
      aligned = (lane % n) == 0;
      e_req   = req_valid && known && aligned;
      e_mis   = req_valid && known && !aligned;
      e_we    = e_req && st;
      if (e_req) e_addr = ea[31:2];
      e_be    = e_req ? 4'(((1 << n) - 1) << lane) : 4'h0;
      e_wdata = (n == 1) ? {4{sdata[7:0]}} : (n == 2) ? {2{sdata[15:0]}} : sdata;
      e_tag   = e_mis ? "R8" : (e_req ? tag : "R9");
      p_ld    = e_req && !st;
      p_idx   = int'(ea[5:2]);
      p_lane  = lane;
      p_n     = n;
      p_sext  = sx;
      p_tag   = tag;
    end
  end

  always @(negedge clk) begin
    if (run_checks && rst_n) begin
      chk(e_tag, "mem_req_o", {31'h0, mem_req_o}, {31'h0, e_req});
      chk(e_tag, "misaligned_o", {31'h0, misaligned_o}, {31'h0, e_mis});
      chk(e_tag, "mem_be_o", {28'h0, mem_be_o}, {28'h0, e_be});
      if (e_req) begin
        chk("R1", "mem_addr_o", {2'b0, mem_addr_o}, {2'b0, e_addr});
        chk(e_tag, "mem_we_o", {31'h0, mem_we_o}, {31'h0, e_we});
      end
      if (e_we) chk(e_tag, "mem_wdata_o", mem_wdata_o, e_wdata);
      chk(e_lv ? e_ltag : "R9", "load_valid_o", {31'h0, load_valid_o}, {31'h0, e_lv});
      if (e_lv) chk(e_ltag, "load_data_o", load_data_o, e_ld);
      else      chk("R9", "load_data_o idle", load_data_o, 32'h0);
    end
  end

  task automatic op(input bit v, input logic [5:0] opc, input logic [31:0] b,
                    input logic [15:0] off, input logic [31:0] d);
    @(negedge clk);
    req_valid = v; opcode = opc; base = b; offset = off; sdata = d;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) op(0, 6'b000000, 32'h0, 16'h0, 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h7F80_807F ^ (32'h0101_0101 * i);
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", "mem_req_o", {31'h0, mem_req_o}, 32'h0);
    chk("R10", "mem_we_o", {31'h0, mem_we_o}, 32'h0);
    chk("R10", "mem_be_o", {28'h0, mem_be_o}, 32'h0);
    chk("R10", "misaligned_o", {31'h0, misaligned_o}, 32'h0);
    chk("R10", "load_valid_o", {31'h0, load_valid_o}, 32'h0);
    rst_n = 1'b1;
    run_checks = 1;
    idle(2);
    // R4 and R1: word store with negative displacement, then R7 word load
    op(1, 6'b101011, 32'h0000_0020, 16'hFFF0, 32'hDEAD_BEEF);
    op(1, 6'b100011, 32'h0000_0010, 16'h0000, 32'h0);
    // R1: base carry wraps past bit 31
    op(1, 6'b100011, 32'hFFFF_FFF0, 16'h0020, 32'h0);
    // R5: byte loads, both extensions, every lane
    for (int l = 0; l < 4; l++) begin
      op(1, 6'b100000, 32'h0000_0010, 16'(l), 32'h0);
      op(1, 6'b100100, 32'h0000_0010, 16'(l), 32'h0);
    end
    // R6: halfword loads at both halves
    for (int l = 0; l < 4; l += 2) begin
      op(1, 6'b100001, 32'h0000_0010, 16'(l), 32'h0);
      op(1, 6'b100101, 32'h0000_0010, 16'(l), 32'h0);
    end
    // R2: byte stores at each lane, R3: halfword stores, then read back
    for (int l = 0; l < 4; l++) op(1, 6'b101000, 32'h0000_0014, 16'(l), 32'h1234_56A0 + 32'(l));
    op(1, 6'b100011, 32'h0000_0014, 16'h0000, 32'h0);
    op(1, 6'b101001, 32'h0000_0018, 16'h0000, 32'hAAAA_8001);
    op(1, 6'b101001, 32'h0000_0018, 16'h0002, 32'h5555_7FFE);
    op(1, 6'b100011, 32'h0000_0018, 16'h0000, 32'h0);
    // R8: misaligned halfword and word, loads and stores
    op(1, 6'b100001, 32'h0000_0011, 16'h0000, 32'h0);
    op(1, 6'b101001, 32'h0000_0013, 16'h0000, 32'h0);
    for (int l = 1; l < 4; l++) begin
      op(1, 6'b100011, 32'h0000_0010, 16'(l), 32'h0);
      op(1, 6'b101011, 32'h0000_0010, 16'(l), 32'hFFFF_FFFF);
    end
    op(1, 6'b100011, 32'h0000_0010, 16'h0000, 32'h0);
    // R9: unknown opcodes and valid held low
    op(1, 6'b001000, 32'h0000_0010, 16'h0000, 32'h0);
    op(1, 6'b101010, 32'h0000_0010, 16'h0000, 32'h0);
    op(0, 6'b101011, 32'h0000_0010, 16'h0000, 32'h0BAD_0BAD);
    op(1, 6'b100011, 32'h0000_0010, 16'h0000, 32'h0);
    // mixed back-to-back sweep
    for (int i = 0; i < 600; i++) begin
      logic [5:0] opcs [9];
      opcs = '{6'b100000, 6'b100100, 6'b100001, 6'b100101, 6'b100011,
               6'b101000, 6'b101001, 6'b101011, 6'b000010};
      op(($urandom % 10) != 0, opcs[$urandom % 9], $urandom, 16'($urandom), $urandom);
    end
    idle(4);
    summary();
  end

endmodule